// File: doc/BRIEF.md
# ADC Scan Trigger and Stop Controller

This block decides when a conversion scan of an analog-to-digital converter begins, pauses, resumes and ends. Software drives it through one 16-bit control word. That word holds a stop bit, a write-only start bit, a sync-enable bit and a 3-bit scan-mode field. A scan can also begin on a rising edge of an external, asynchronous sync input. The sync input passes through a two-stage synchronizer and an edge detector before it is used.

Once a scan is accepted, the block stays busy until the sequencer reports that the scan is done. It leaves busy early only if software sets stop. The sequencer sees a one-cycle sample request each time a scan starts or resumes. If the sequencer raises its pause input, the next accepted sync edge resumes the scan without leaving busy. In the two once modes, the sync enable clears itself as soon as the first sync edge is accepted.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, `busy_o` and `sample_req_o` are 0 and `reg_rdata_o` reads 16'h0000.
- R2: The register field positions are: stop at bit 14, start at bit 13, sync enable at bit 12, scan mode at bits 2:0. Bits 15 and 11:3 always read 0 and ignore writes. Stop, sync enable and mode read back the value last written, one cycle after the write.
- R3: A write with stop (bit 14) set clears `busy_o` at the next clock edge. No sample request is issued while stop reads 1.
- R4: While stop is 1, start writes and sync edges are discarded. This includes a single write that sets stop and start together.
- R5: Writing 1 to start (bit 13) while idle and not stopped sets `busy_o` and pulses `sample_req_o` for one cycle, both at the next edge. Writing 0 to start does nothing. Start always reads 0.
- R6: A start write while `busy_o` is 1 issues no sample request and leaves `busy_o` at 1.
- R7: With sync enable set, a rising edge on `sync_i` driven before clock edge k sets `busy_o` and `sample_req_o` at edge k+2, which is the third edge.
- R8: A sync edge is ignored while `busy_o` is 1 and `pause_i` is 0. A sync edge is also ignored while sync enable is 0.
- R9: In modes 3'b000 and 3'b001, accepting a sync edge clears sync enable. In other modes, sync enable stays set.
- R10: With `busy_o` at 1 and `pause_i` at 1, an accepted sync edge pulses `sample_req_o` and `busy_o` stays 1. `sample_req_o` is never 1 while `busy_o` is 0.
- R11: `scan_done_i` clears `busy_o` at the next edge. It takes priority over a resume in the same cycle, so no request is issued.
- R12: A start write and an accepted sync edge in the same cycle produce exactly one scan and exactly one sample-request pulse.
- R13: Holding `sync_i` high produces only one edge, so it causes at most one start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Control-word write strobe |
| reg_wdata_i | input | 16 | Control-word write data |
| reg_rdata_o | output | 16 | Control-word read value |
| sync_i | input | 1 | Asynchronous external sync trigger |
| pause_i | input | 1 | Sequencer is waiting for another sync edge |
| scan_done_i | input | 1 | Sequencer finished the current scan |
| busy_o | output | 1 | Scan in progress |
| sample_req_o | output | 1 | One-cycle pulse when a scan starts or resumes |

## Verification
Two triggers can land in the same cycle, and the bench provokes both kinds of collision. In the first, a start write is timed to reach the same clock edge as a synchronized sync edge. The bench judges it by seeing exactly one request pulse and no second pulse after it. In the second, a resume edge arrives together with scan done, and the bench expects busy to drop with no request. The bench also times a self-clearing sync enable against register writes. For the random phase, a cycle model built from the requirements predicts busy, the request and the read value on every cycle.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int unsigned CTRL_W      = 16;
  localparam int unsigned MODE_W      = 3;
  localparam int unsigned BIT_RSVD    = 15;
  localparam int unsigned BIT_STOP    = 14;
  localparam int unsigned BIT_START   = 13;
  localparam int unsigned BIT_SYNC_EN = 12;

  // modes 000 and 001 are single-trigger modes
  function automatic logic mode_is_once(input logic [MODE_W-1:0] mode);
    return (mode[MODE_W-1:1] == '0);
  endfunction
endpackage

// File: rtl/adc_sync_edge.sv
module adc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

  assert_single_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              sync_clr_i,
  output logic              stop_o,
  output logic              stop_nxt_o,
  output logic              start_req_o,
  output logic              sync_en_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [CTRL_W-1:0] rdata_o
);
  logic              stop_q, sync_en_q;
  logic [MODE_W-1:0] mode_q;
  logic              unused_bits;

  assign unused_bits = ^{wdata_i[BIT_RSVD], wdata_i[BIT_SYNC_EN-1:MODE_W]};

  assign stop_nxt_o  = wr_i ? wdata_i[BIT_STOP] : stop_q;
  assign start_req_o = wr_i & wdata_i[BIT_START];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q    <= 1'b0;
      sync_en_q <= 1'b0;
      mode_q    <= '0;
    end else begin
      stop_q <= stop_nxt_o;
      if (wr_i) mode_q <= wdata_i[MODE_W-1:0];
      // self-clear wins over a same-cycle write
      if (sync_clr_i)  sync_en_q <= 1'b0;
      else if (wr_i)   sync_en_q <= wdata_i[BIT_SYNC_EN];
    end
  end

  always_comb begin
    rdata_o                 = '0;
    rdata_o[BIT_STOP]       = stop_q;
    rdata_o[BIT_SYNC_EN]    = sync_en_q;
    rdata_o[MODE_W-1:0]     = mode_q;
  end

  assign stop_o    = stop_q;
  assign sync_en_o = sync_en_q;
  assign mode_o    = mode_q;

  assert_once_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_clr_i |=> !sync_en_q);
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_req_i,
  input  logic              sync_rise_i,
  input  logic              sync_en_i,
  input  logic              stop_nxt_i,
  input  logic              pause_i,
  input  logic              done_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              busy_o,
  output logic              sample_req_o,
  output logic              sync_clr_o
);
  logic busy_q, req_q;
  logic start_ok, sync_ok, new_scan, resume;

  assign start_ok = start_req_i & ~stop_nxt_i & ~busy_q;
  assign sync_ok  = sync_rise_i & sync_en_i & ~stop_nxt_i & (~busy_q | pause_i);
  assign new_scan = start_ok | (sync_ok & ~busy_q);
  assign resume   = sync_ok & busy_q & ~done_i;
  assign sync_clr_o = sync_ok & mode_is_once(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= new_scan | resume;
      if (stop_nxt_i)    busy_q <= 1'b0;
      else if (new_scan) busy_q <= 1'b1;
      else if (done_i)   busy_q <= 1'b0;
    end
  end

  assign busy_o       = busy_q;
  assign sample_req_o = req_q;

  assert_req_needs_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> busy_q);
  assert_start_has_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> req_q);
  assert_done_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_i && !new_scan) |=> !busy_q);
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [CTRL_W-1:0] reg_rdata_o,
  input  logic              sync_i,
  input  logic              pause_i,
  input  logic              scan_done_i,
  output logic              busy_o,
  output logic              sample_req_o
);
  logic              sync_rise, stop_q, stop_nxt, start_req, sync_en, sync_clr;
  logic [MODE_W-1:0] mode;

  adc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (sync_i),
    .rise_o  (sync_rise)
  );

  adc_ctrl_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .wdata_i     (reg_wdata_i),
    .sync_clr_i  (sync_clr),
    .stop_o      (stop_q),
    .stop_nxt_o  (stop_nxt),
    .start_req_o (start_req),
    .sync_en_o   (sync_en),
    .mode_o      (mode),
    .rdata_o     (reg_rdata_o)
  );

  adc_scan_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_req_i  (start_req),
    .sync_rise_i  (sync_rise),
    .sync_en_i    (sync_en),
    .stop_nxt_i   (stop_nxt),
    .pause_i      (pause_i),
    .done_i       (scan_done_i),
    .mode_i       (mode),
    .busy_o       (busy_o),
    .sample_req_o (sample_req_o),
    .sync_clr_o   (sync_clr)
  );

  assert_stop_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q |-> !busy_o);
  assert_stop_no_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q |-> !sample_req_o);
endmodule

// File: tb/adc_scan_ctrl_tb.sv
module adc_scan_ctrl_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0, sync = 1'b0, pause = 1'b0, done = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        busy, req;
  int          checks = 0, fails = 0;

  // requirement model state
  logic m_busy = 0, m_req = 0, m_stop = 0, m_sen = 0;
  logic [2:0] m_mode = '0;
  logic s1 = 0, s2 = 0, s3 = 0;

  always #10 clk = ~clk;

  adc_scan_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sync_i(sync), .pause_i(pause), .scan_done_i(done),
    .busy_o(busy), .sample_req_o(req)
  );

  function automatic logic [15:0] m_rdata();
    return {1'b0, m_stop, 1'b0, m_sen, 9'b0, m_mode};
  endfunction

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model, sample at next negedge
  task automatic cyc(input logic w, input logic [15:0] d, input logic sy,
                     input logic pa, input logic dn);
    logic edg, stop_n, sta, sya, news, res;
    wr = w; wdata = d; sync = sy; pause = pa; done = dn;
    edg = s2 & ~s3; s3 = s2; s2 = s1; s1 = sy;
    stop_n = w ? d[14] : m_stop;
    sta  = w & d[13] & ~stop_n & ~m_busy;
    sya  = edg & m_sen & ~stop_n & (~m_busy | pa);
    news = sta | (sya & ~m_busy);
    res  = sya & m_busy & ~dn;
    m_req = news | res;
    m_busy = stop_n ? 1'b0 : news ? 1'b1 : dn ? 1'b0 : m_busy;
    if (sya && m_mode[2:1] == 2'b00) m_sen = 1'b0;
    else if (w) m_sen = d[12];
    if (w) m_mode = d[2:0];
    m_stop = stop_n;
    @(posedge clk); @(negedge clk);
    wr = 0;
  endtask

  task automatic idle(input int n, input logic sy);
    for (int i = 0; i < n; i++) cyc(0, 16'h0, sy, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 req", req, 0); chk("R1 rdata", rdata, 16'h0);

    // R2/R5: all bits except stop written, start launches scan
    cyc(1, 16'hBFFF, 0, 0, 0);
    chk("R2 rdata", rdata, 16'h1007); chk("R5 busy", busy, 1); chk("R5 req", req, 1);
    idle(1, 0);
    chk("R5 req pulse", req, 0); chk("R5 busy held", busy, 1);
    // R6
    cyc(1, 16'h2007, 0, 0, 0);
    chk("R6 req", req, 0); chk("R6 busy", busy, 1); chk("R5 start reads 0", rdata, 16'h0007);
    // R11
    cyc(0, 0, 0, 0, 1);
    chk("R11 busy", busy, 0);
    cyc(1, 16'h0003, 0, 0, 0);
    chk("R5 zero write busy", busy, 0); chk("R5 zero write req", req, 0);
    // R7 / R13 / R9 (mode 3 keeps enable)
    cyc(1, 16'h1003, 0, 0, 0);
    idle(2, 1);
    chk("R7 not yet", busy, 0);
    idle(1, 1);
    chk("R7 busy", busy, 1); chk("R7 req", req, 1);
    idle(3, 1);
    chk("R13 held high", req, 0); chk("R9 mode3 keeps enable", rdata, 16'h1003);
    // R8 busy not paused
    idle(3, 0);
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 1, 0, 0);
      chk("R8 busy unpaused", req, 0);
    end
    idle(3, 0);
    // R10 resume
    cyc(0, 0, 1, 1, 0); cyc(0, 0, 1, 1, 0); cyc(0, 0, 1, 1, 0);
    chk("R10 resume req", req, 1); chk("R10 busy stays", busy, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R11 done", busy, 0);
    // R9 once mode clears enable
    cyc(1, 16'h1001, 0, 0, 0);
    idle(1, 0);
    idle(3, 1);
    chk("R9 scan", busy, 1); chk("R9 enable cleared", rdata, 16'h0001);
    cyc(0, 0, 0, 0, 1);
    idle(2, 0); idle(3, 1);
    chk("R8 disabled sync", busy, 0); chk("R8 disabled req", req, 0);
    // R3 / R4
    cyc(1, 16'h2000, 0, 0, 0);
    chk("R5 start", busy, 1);
    cyc(1, 16'h4000, 0, 0, 0);
    chk("R3 stop busy", busy, 0); chk("R3 stop req", req, 0); chk("R3 rdata", rdata, 16'h4000);
    cyc(1, 16'h6000, 0, 0, 0);
    chk("R4 stop+start", busy, 0); chk("R4 stop+start req", req, 0);
    cyc(1, 16'h5000, 0, 0, 0);
    idle(3, 1);
    chk("R4 sync in stop", busy, 0); chk("R4 rdata", rdata, 16'h5000);
    cyc(1, 16'h0000, 0, 0, 0);
    idle(3, 0);
    // R11 priority over resume
    cyc(1, 16'h3003, 0, 0, 0);
    chk("R5 start+en", busy, 1);
    cyc(0, 0, 1, 1, 0); cyc(0, 0, 1, 1, 0); cyc(0, 0, 1, 1, 1);
    chk("R11 prio busy", busy, 0); chk("R11 prio req", req, 0);
    idle(3, 0);
    // R12 start and sync collide
    idle(2, 1);
    cyc(1, 16'h3003, 1, 0, 0);
    chk("R12 busy", busy, 1); chk("R12 req", req, 1);
    idle(1, 1);
    chk("R12 single req", req, 0);
    cyc(0, 0, 0, 0, 1);
    idle(3, 0);

    // random phase vs requirement model
    for (int n = 0; n < 3000; n++) begin
      logic w, sy, pa, dn;
      logic [15:0] d;
      w  = ($urandom % 6) == 0;
      d  = 16'($urandom);
      d[14] = ($urandom % 8) == 0;
      sy = (($urandom % 4) == 0) ? ~sync : sync;
      pa = ($urandom % 3) == 0;
      dn = ($urandom % 10) == 0;
      cyc(w, d, sy, pa, dn);
      chk("R12 rand busy", {15'b0, busy}, {15'b0, m_busy});
      chk("R10 rand req", {15'b0, req}, {15'b0, m_req});
      chk("R2 rand rdata", rdata, m_rdata());
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule